// File: doc/BRIEF.md
# Non-Volatile Bank Row-Buffer Controller

This block fronts one bank of a non-volatile main memory. Opening a row copies it into a separate row buffer without destroying the array contents. After that copy, reads and writes to the open row are served from the buffer alone. The controller accepts one request at a time. Each request carries a write flag, a row, a block index inside the row and one block of data. The controller tracks which row is open and keeps dirty state both for the whole row and for each block. It issues activate and block-write strobes to the array, and it signals completion with a one-cycle done pulse that carries any read data. The cells do not need refresh, so there is no refresh logic.

Latency is modelled with cycle counters. A buffer hit takes a fixed number of cycles. A row switch takes a longer fixed time, plus one write-pulse time for every block written back before the new row is activated. A static two-bit mode input selects the writeback policy:

- **Whole-row dirty flag:** one dirty flag covers the whole row.
- **Per-block dirty flags:** each block of the row has its own dirty flag.
- **Write bypass:** writes go straight to the array, so the buffer never becomes dirty.

Three counters report hits, row switches and written-back blocks.

Top module: `nvm_rowbuf_ctrl`

## Requirements
- R1: While reset is high and after it is released, req_ready is 1, done is 0, arr_act and arr_wr are 0, all three counters are 0, no row is open and no dirty state is held.
- R2: After reset, the first access of any kind activates the requested row and writes nothing back. It completes CONF_LAT (default 125) cycles after acceptance.
- R3: An access to the open row (other than a bypass-mode write) is a hit. It completes HIT_LAT (default 75) cycles after acceptance and is served from the buffer. A read returns the block's current value, including data written earlier while the row was open.
- R4: A row switch completes CONF_LAT + k*PULSE_LAT cycles after acceptance, where k is the number of blocks written back (PULSE_LAT defaults to 25). All write strobes come before the activate strobe, and the two strobes never appear together.
- R5: In mode 0 (mode 3 behaves the same way), a row that was written while open has all of its blocks written back on a switch. A row that was not written has none written back.
- R6: In mode 1, a switch writes back only the blocks that were written while the row was open, in ascending block index order.
- R7: In mode 2, a write issues exactly one array write strobe with the request's row, block and data. It completes PULSE_LAT cycles after acceptance and opens no row. If it targets the open row, the buffered copy of that block is updated as well.
- R8: In mode 2, the buffer is never dirty, so no row switch writes anything back.
- R9: req_ready falls in the cycle after a request is accepted and returns together with done. done is high for exactly one cycle.
- R10: cnt_hit counts hits, cnt_conf counts accesses that needed an activation, and cnt_wb counts blocks written back. A bypass-mode write changes none of them.
- R11: A hit write does not touch the array. The array copy of the block keeps its old value until the row is written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Writeback policy: 0/3 whole-row flag, 1 per-block flags, 2 write bypass |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_blk | input | BLK_W | Block index within the row |
| req_wdata | input | DATA_W | Write data for one block |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Read data, valid with done on a read |
| arr_act | output | 1 | Activate strobe: copy row arr_row into the buffer |
| arr_wr | output | 1 | Starts one block write pulse |
| arr_row | output | ROW_W | Row for the array command |
| arr_blk | output | BLK_W | Block for a write pulse |
| arr_wdata | output | DATA_W | Data for a write pulse |
| arr_rdata | input | NBLK*DATA_W | Full row from the array, valid for arr_row while arr_act is high (block 0 in the low bits) |
| cnt_hit | output | CNT_W | Hit count |
| cnt_conf | output | CNT_W | Activation count |
| cnt_wb | output | CNT_W | Written-back block count |

## Verification
The assertions rely on two assumptions about the inputs. First, mode holds still whenever reset is low. Second, the array presents the addressed row combinationally on arr_rdata in the same cycle as arr_act. The bench honours both. It changes mode only while reset is asserted, and its array model drives arr_rdata directly from its storage indexed by arr_row. Requests are offered only while req_ready is high and are withdrawn right after the accepting edge. This keeps every request latched exactly once.

// File: rtl/nvm_rbc_pkg.sv
package nvm_rbc_pkg;
  localparam logic [1:0] MODE_ROWFLAG = 2'd0;
  localparam logic [1:0] MODE_BLKFLAG = 2'd1;
  localparam logic [1:0] MODE_BYPASS  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_OPEN,
    ST_APPLY,
    ST_DIRECT,
    ST_HOLD
  } ctrl_st_e;
endpackage

// File: rtl/nvm_rbc_wbsel.sv
module nvm_rbc_wbsel
  import nvm_rbc_pkg::*;
#(
  parameter int NBLK = 4
) (
  input  logic [1:0]      mode,
  input  logic            row_open,
  input  logic            row_dirty,
  input  logic [NBLK-1:0] blk_dirty,
  output logic [NBLK-1:0] flush_mask
);
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_comb begin
      if (!row_open || mode == MODE_BYPASS) flush_mask[g] = 1'b0;
      else if (mode == MODE_BLKFLAG)        flush_mask[g] = blk_dirty[g];
      else                                  flush_mask[g] = row_dirty;
    end
  end
endmodule

// File: rtl/nvm_rbc_lowbit.sv
module nvm_rbc_lowbit #(
  parameter int NBLK  = 4,
  localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic [NBLK-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvm_rbc_lat.sv
module nvm_rbc_lat #(
  parameter int NBLK      = 4,
  parameter int CONF_LAT  = 125,
  parameter int PULSE_LAT = 25,
  parameter int LAT_W     = 16
) (
  input  logic [NBLK-1:0]  mask,
  output logic [LAT_W-1:0] total
);
  logic [LAT_W-1:0] nset;
  always_comb begin
    nset = '0;
    for (int i = 0; i < NBLK; i++) nset = nset + LAT_W'(mask[i]);
    total = LAT_W'(CONF_LAT) + nset * LAT_W'(PULSE_LAT);
  end
endmodule

// File: rtl/nvm_rowbuf_ctrl.sv
module nvm_rowbuf_ctrl
  import nvm_rbc_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int NBLK      = 4,
  parameter int DATA_W    = 16,
  parameter int HIT_LAT   = 75,
  parameter int CONF_LAT  = 125,
  parameter int PULSE_LAT = 25,
  parameter int CNT_W     = 16,
  localparam int BLK_W    = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int ROW_DW   = NBLK * DATA_W,
  localparam int LAT_W    = $clog2(CONF_LAT + NBLK * PULSE_LAT + HIT_LAT + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              arr_act,
  output logic              arr_wr,
  output logic [ROW_W-1:0]  arr_row,
  output logic [BLK_W-1:0]  arr_blk,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [ROW_DW-1:0] arr_rdata,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_conf,
  output logic [CNT_W-1:0]  cnt_wb
);
  ctrl_st_e          st_q;
  logic              open_q, row_dirty_q;
  logic [ROW_W-1:0]  open_row_q;
  logic [NBLK-1:0]   blk_dirty_q, pend_q;
  logic [DATA_W-1:0] rbuf [NBLK];
  logic              r_we;
  logic [ROW_W-1:0]  r_row;
  logic [BLK_W-1:0]  r_blk;
  logic [DATA_W-1:0] r_wdata;
  logic [LAT_W-1:0]  remain_q, pulse_q, conf_total;
  logic [NBLK-1:0]   flush_mask;
  logic [BLK_W-1:0]  next_blk;
  logic              pend_any, is_hit, is_bypass;

  assign is_hit    = open_q && (open_row_q == req_row);
  assign is_bypass = (mode == MODE_BYPASS);

  nvm_rbc_wbsel #(.NBLK(NBLK)) wbsel_i (
    .mode(mode), .row_open(open_q), .row_dirty(row_dirty_q),
    .blk_dirty(blk_dirty_q), .flush_mask(flush_mask)
  );

  nvm_rbc_lowbit #(.NBLK(NBLK)) lowbit_i (
    .vec(pend_q), .idx(next_blk), .any(pend_any)
  );

  nvm_rbc_lat #(.NBLK(NBLK), .CONF_LAT(CONF_LAT), .PULSE_LAT(PULSE_LAT),
                .LAT_W(LAT_W)) lat_i (
    .mask(flush_mask), .total(conf_total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      req_ready   <= 1'b1;
      done        <= 1'b0;
      rd_data     <= '0;
      arr_act     <= 1'b0;
      arr_wr      <= 1'b0;
      arr_row     <= '0;
      arr_blk     <= '0;
      arr_wdata   <= '0;
      open_q      <= 1'b0;
      open_row_q  <= '0;
      row_dirty_q <= 1'b0;
      blk_dirty_q <= '0;
      pend_q      <= '0;
      remain_q    <= '0;
      pulse_q     <= '0;
      r_we        <= 1'b0;
      r_row       <= '0;
      r_blk       <= '0;
      r_wdata     <= '0;
      cnt_hit     <= '0;
      cnt_conf    <= '0;
      cnt_wb      <= '0;
    end else begin
      done    <= 1'b0;
      arr_act <= 1'b0;
      arr_wr  <= 1'b0;
      if (st_q != ST_IDLE && remain_q != '0) remain_q <= remain_q - 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            r_we      <= req_we;
            r_row     <= req_row;
            r_blk     <= req_blk;
            r_wdata   <= req_wdata;
            if (is_bypass && req_we) begin
              st_q     <= ST_DIRECT;
              remain_q <= LAT_W'(PULSE_LAT - 1);
            end else if (is_hit) begin
              st_q     <= ST_APPLY;
              remain_q <= LAT_W'(HIT_LAT - 1);
              cnt_hit  <= cnt_hit + 1'b1;
            end else begin
              st_q     <= ST_FLUSH;
              remain_q <= conf_total - 1'b1;
              pend_q   <= flush_mask;
              pulse_q  <= '0;
              cnt_conf <= cnt_conf + 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
          end else if (pend_any) begin
            arr_wr           <= 1'b1;
            arr_row          <= open_row_q;
            arr_blk          <= next_blk;
            arr_wdata        <= rbuf[next_blk];
            pend_q[next_blk] <= 1'b0;
            pulse_q          <= LAT_W'(PULSE_LAT - 1);
            cnt_wb           <= cnt_wb + 1'b1;
          end else begin
            arr_act <= 1'b1;
            arr_row <= r_row;
            st_q    <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          for (int i = 0; i < NBLK; i++) rbuf[i] <= arr_rdata[i*DATA_W +: DATA_W];
          open_q      <= 1'b1;
          open_row_q  <= r_row;
          row_dirty_q <= 1'b0;
          blk_dirty_q <= '0;
          st_q        <= ST_APPLY;
        end
        ST_APPLY: begin
          if (r_we) begin
            rbuf[r_blk]        <= r_wdata;
            row_dirty_q        <= 1'b1;
            blk_dirty_q[r_blk] <= 1'b1;
          end else begin
            rd_data <= rbuf[r_blk];
          end
          st_q <= ST_HOLD;
        end
        ST_DIRECT: begin
          arr_wr    <= 1'b1;
          arr_row   <= r_row;
          arr_blk   <= r_blk;
          arr_wdata <= r_wdata;
          if (open_q && open_row_q == r_row) rbuf[r_blk] <= r_wdata;
          st_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (remain_q == '0) begin
            done      <= 1'b1;
            req_ready <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_rbc_chk.sv
module nvm_rbc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic             arr_act,
  input logic             arr_wr,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_wb
);
  // R9: ready drops right after acceptance
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R9: completion strobe lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: activate and write strobes never coincide
  assert_no_strobe_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(arr_act && arr_wr));
  // R2: array commands only while a request is in flight
  assert_cmd_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (arr_act || arr_wr) |-> !req_ready);
  // R8: bypass mode never writes anything back
  assert_bypass_no_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |-> $stable(cnt_wb));
  // R10: hit counter steps by one at most
  assert_hit_step_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_hit != $past(cnt_hit)) |-> (cnt_hit == $past(cnt_hit) + 1'b1));
  // R5: input assumption, mode is static outside reset
  assert_mode_static_R5: assert property (@(posedge clk) disable iff (rst)
    $stable(mode));
endmodule

bind nvm_rowbuf_ctrl nvm_rbc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid),
  .req_ready(req_ready), .done(done), .arr_act(arr_act), .arr_wr(arr_wr),
  .cnt_hit(cnt_hit), .cnt_wb(cnt_wb)
);

// File: tb/nvm_rowbuf_ctrl_tb_top.sv
module nvm_rowbuf_ctrl_tb_top;
  localparam int ROW_W = 4, NBLK = 4, DATA_W = 16, CNT_W = 16;
  localparam int ROWS = 1 << ROW_W, BLK_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [BLK_W-1:0] req_blk = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, done, arr_act, arr_wr;
  logic [DATA_W-1:0] rd_data, arr_wdata;
  logic [ROW_W-1:0] arr_row;
  logic [BLK_W-1:0] arr_blk;
  logic [NBLK*DATA_W-1:0] arr_rdata;
  logic [CNT_W-1:0] cnt_hit, cnt_conf, cnt_wb;

  int errors = 0, checks = 0;
  logic [DATA_W-1:0] mem [ROWS][NBLK];
  int wr_n;
  int wr_log [16];

  always #2 clk = ~clk;

  nvm_rowbuf_ctrl dut_i (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_row(req_row), .req_blk(req_blk), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .arr_act(arr_act), .arr_wr(arr_wr),
    .arr_row(arr_row), .arr_blk(arr_blk), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .cnt_hit(cnt_hit), .cnt_conf(cnt_conf), .cnt_wb(cnt_wb)
  );

  function automatic logic [DATA_W-1:0] initval(input int r, input int b);
    return DATA_W'(16'hA000 + r * 16 + b);
  endfunction

  always_comb
    for (int b = 0; b < NBLK; b++) arr_rdata[b*DATA_W +: DATA_W] = mem[arr_row][b];

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++)
        for (int b = 0; b < NBLK; b++) mem[r][b] <= initval(r, b);
      wr_n <= 0;
    end else if (arr_wr) begin
      mem[arr_row][arr_blk] <= arr_wdata;
      if (wr_n < 16) wr_log[wr_n] <= int'(arr_blk);
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1;
    mode = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_req(input bit we, input int row, input int blk, input int data,
                        output int lat, output int rdv);
    int n;
    @(negedge clk);
    req_valid = 1'b1;
    req_we = we;
    req_row = ROW_W'(row);
    req_blk = BLK_W'(blk);
    req_wdata = DATA_W'(data);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready low after accept", int'(req_ready), 0);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    lat = n;
    rdv = int'(rd_data);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", int'(done), 0);
    chk(req_ready == 1'b1, "R9", "ready back after done", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "ready/done after reset",
        int'({req_ready, done}), 2);
    chk(arr_act == 1'b0 && arr_wr == 1'b0, "R1", "no array strobe", int'({arr_act, arr_wr}), 0);
    chk(cnt_hit == 0 && cnt_conf == 0 && cnt_wb == 0, "R1", "counters zero",
        int'(cnt_hit) + int'(cnt_conf) + int'(cnt_wb), 0);
  endtask

  task automatic t_rowflag();
    int lat, rdv;
    do_reset(2'd0);
    do_req(1'b0, 3, 1, 0, lat, rdv);
    chk(lat == 125, "R2", "cold miss latency", lat, 125);
    chk(rdv == int'(initval(3, 1)), "R2", "cold read data", rdv, int'(initval(3, 1)));
    chk(wr_n == 0, "R2", "no writeback on cold miss", wr_n, 0);
    do_req(1'b1, 3, 2, 16'h1234, lat, rdv);
    chk(lat == 75, "R3", "hit write latency", lat, 75);
    chk(mem[3][2] == initval(3, 2), "R11", "array untouched by hit write",
        int'(mem[3][2]), int'(initval(3, 2)));
    chk(wr_n == 0, "R11", "no pulse on hit write", wr_n, 0);
    do_req(1'b0, 3, 2, 0, lat, rdv);
    chk(lat == 75, "R3", "hit read latency", lat, 75);
    chk(rdv == 16'h1234, "R3", "hit read sees buffered write", rdv, 16'h1234);
    do_req(1'b0, 5, 0, 0, lat, rdv);
    chk(lat == 225, "R4", "dirty switch latency", lat, 225);
    chk(wr_n == 4, "R5", "whole row flushed", wr_n, 4);
    chk(mem[3][2] == 16'h1234, "R5", "dirty block in array", int'(mem[3][2]), 16'h1234);
    chk(mem[3][0] == initval(3, 0), "R5", "clean block rewritten unchanged",
        int'(mem[3][0]), int'(initval(3, 0)));
    chk(rdv == int'(initval(5, 0)), "R4", "new row data", rdv, int'(initval(5, 0)));
    chk(cnt_hit == 2 && cnt_conf == 2 && cnt_wb == 4, "R10", "counters hit/conf/wb",
        int'(cnt_hit) * 100 + int'(cnt_conf) * 10 + int'(cnt_wb), 224);
    do_req(1'b0, 7, 3, 0, lat, rdv);
    chk(lat == 125, "R5", "clean switch latency", lat, 125);
    chk(wr_n == 4, "R5", "clean row skipped", wr_n, 4);
  endtask

  task automatic t_blkflag();
    int lat, rdv;
    do_reset(2'd1);
    do_req(1'b1, 2, 3, 16'hB3B3, lat, rdv);
    chk(lat == 125, "R2", "write cold miss latency", lat, 125);
    do_req(1'b1, 2, 1, 16'hA1A1, lat, rdv);
    chk(lat == 75, "R3", "hit write latency", lat, 75);
    do_req(1'b0, 4, 2, 0, lat, rdv);
    chk(lat == 175, "R6", "partial switch latency", lat, 175);
    chk(wr_n == 2, "R6", "only dirty blocks", wr_n, 2);
    chk(wr_log[0] == 1 && wr_log[1] == 3, "R6", "ascending order",
        wr_log[0] * 10 + wr_log[1], 13);
    chk(mem[2][1] == 16'hA1A1 && mem[2][3] == 16'hB3B3, "R6", "flushed data",
        int'(mem[2][1]), 16'hA1A1);
    chk(cnt_wb == 2, "R10", "wb counter", int'(cnt_wb), 2);
  endtask

  task automatic t_bypass();
    int lat, rdv;
    do_reset(2'd2);
    do_req(1'b0, 6, 0, 0, lat, rdv);
    chk(lat == 125, "R2", "bypass cold read", lat, 125);
    do_req(1'b1, 6, 0, 16'hC0C0, lat, rdv);
    chk(lat == 25, "R7", "bypass write latency", lat, 25);
    chk(mem[6][0] == 16'hC0C0, "R7", "bypass write in array", int'(mem[6][0]), 16'hC0C0);
    chk(wr_n == 1, "R7", "one pulse", wr_n, 1);
    do_req(1'b0, 6, 0, 0, lat, rdv);
    chk(lat == 75 && rdv == 16'hC0C0, "R7", "open row buffer updated", rdv, 16'hC0C0);
    do_req(1'b1, 9, 1, 16'hD1D1, lat, rdv);
    chk(lat == 25, "R7", "bypass write other row", lat, 25);
    chk(cnt_hit == 1 && cnt_conf == 1, "R10", "bypass write not counted",
        int'(cnt_hit) * 10 + int'(cnt_conf), 11);
    do_req(1'b0, 8, 0, 0, lat, rdv);
    chk(lat == 125, "R8", "switch with no writeback", lat, 125);
    chk(cnt_wb == 0 && wr_n == 2, "R8", "nothing written back", int'(cnt_wb), 0);
    do_req(1'b0, 9, 1, 0, lat, rdv);
    chk(rdv == 16'hD1D1, "R7", "bypassed data readable", rdv, 16'hD1D1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_rowflag();
    t_blkflag();
    t_bypass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule